// File: doc/BRIEF.md
# Fragment Dual-Issue Generator with Selective Reissue

This block sits between a source of fragments and the queue that feeds a pool of shader workers. With reliable mode on, every fragment it accepts goes out twice, back to back, so that two independent workers compute the same domain element and a checker further down the pipe can compare their results. With reliable mode off, fragments pass through once, for work that needs no protection.

When the checker finds a mismatch, it sends the failing element's (x,y) coordinate back on a request port. The generator registers the request and marks that coordinate in a one-bit-per-element mask that covers a parameterized compute domain. Marked coordinates are regenerated in duplicate, in ascending linear order, and take precedence over new input whenever a fresh output beat is chosen. Only failed elements are recomputed. A busy flag reports that reissue work is still outstanding.

Top module: `fdg_dual_issue`

## Requirements
- R1: While reset is asserted, and after its release with no stimulus, out_valid, in_ready and busy are all low.
- R2: With dup_en high, each input fragment is emitted as two consecutive accepted output beats carrying identical x, y and data, with out_replay low.
- R3: in_ready is high only in a cycle where the last copy of the offered input fragment is accepted (the second copy in reliable mode, the only copy in pass-through mode); it is never high during a replay beat.
- R4: With dup_en low, each input fragment produces exactly one output beat, and in_ready equals out_ready while that fragment is offered.
- R5: A request sampled with rq_valid high at clock edge k makes busy high after edge k; its coordinate enters the mask at edge k+1 and can be offered on the output from then on.
- R6: Whenever no output beat is pending, a non-empty mask wins over a waiting input fragment.
- R7: A replay beat has out_replay = 1, out_data all zero and the requested coordinate; each replay is emitted as two consecutive beats whatever dup_en is, and its mask entry is cleared when the second beat is accepted.
- R8: Marked coordinates are replayed lowest linear index first, where the index is y*DOM_W + x.
- R9: Requests that arrive while replay is running are added to the mask and replayed later; a repeated request for a coordinate that is still marked gives a single replay pair.
- R10: Once out_valid is high while out_ready is low, in the next cycle out_valid is still high and out_x, out_y, out_data and out_replay are unchanged (given a stable input).
- R11: busy is high while any mask entry is set or a captured request has not yet reached the mask, and low otherwise.
- R12: A pair is never split: after the first copy of a pair is accepted, the next accepted beat is its second copy, even if a lower-index request arrives in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dup_en | input | 1 | Reliable mode: emit each input fragment twice |
| in_valid | input | 1 | Input fragment valid |
| in_ready | output | 1 | Input fragment consumed this cycle |
| in_x | input | XW | Input fragment x coordinate |
| in_y | input | YW | Input fragment y coordinate |
| in_data | input | DATA_W | Input fragment payload |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream queue can take a beat |
| out_x | output | XW | Output x coordinate |
| out_y | output | YW | Output y coordinate |
| out_data | output | DATA_W | Output payload (zero on replay beats) |
| out_replay | output | 1 | Beat is a regenerated (reissued) fragment |
| rq_valid | input | 1 | Reissue request valid |
| rq_x | input | XW | Reissue request x coordinate |
| rq_y | input | YW | Reissue request y coordinate |
| busy | output | 1 | Reissue work outstanding |

## Verification
The hardest situations to reach are a reissue request that lands exactly between the two copies of a replay pair, and requests that land while an input fragment is already offered on a stalled output. The bench produces both by holding out_ready low, timing the request against the two-stage capture path, and then opening out_ready for a single cycle so that exactly one beat is accepted before the next request arrives. Ordering is checked by issuing coordinates out of order, including a duplicate, while the output is held, and then releasing the output into a scoreboard that already holds the sorted sequence.

// File: rtl/fdg_pkg.sv
package fdg_pkg;

    // Where the current output beat stands within its pair.
    typedef enum logic [1:0] {
        PH_FREE   = 2'd0,  // nothing committed, choose a new source
        PH_HELD   = 2'd1,  // first beat offered but not yet taken
        PH_SECOND = 2'd2   // first beat taken, second copy pending
    } phase_e;

    // Origin of the beat on the output.
    typedef enum logic {
        SRC_IN  = 1'b0,
        SRC_RPL = 1'b1
    } src_e;

endpackage

// File: rtl/fdg_req_stage.sv
module fdg_req_stage #(
    parameter int XW = 4,
    parameter int YW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rq_valid,
    input  logic [XW-1:0] rq_x,
    input  logic [YW-1:0] rq_y,
    output logic          stg_valid,
    output logic [XW-1:0] stg_x,
    output logic [YW-1:0] stg_y
);

    typedef struct packed {
        logic          v;
        logic [XW-1:0] x;
        logic [YW-1:0] y;
    } stg_t;

    stg_t stg_d, stg_q;

    always_comb begin
        stg_d.v = rq_valid;
        stg_d.x = rq_valid ? rq_x : stg_q.x;
        stg_d.y = rq_valid ? rq_y : stg_q.y;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign stg_valid = stg_q.v;
    assign stg_x     = stg_q.x;
    assign stg_y     = stg_q.y;

endmodule

// File: rtl/fdg_mask.sv
module fdg_mask #(
    parameter int DOM_W = 16,
    parameter int DOM_H = 16,
    parameter int XW    = 4,
    parameter int YW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [XW-1:0] set_x,
    input  logic [YW-1:0] set_y,
    input  logic          clr_en,
    input  logic [XW-1:0] clr_x,
    input  logic [YW-1:0] clr_y,
    output logic          any,
    output logic [XW-1:0] pick_x,
    output logic [YW-1:0] pick_y
);

    localparam int NCELL = DOM_W * DOM_H;

    logic [NCELL-1:0] mask_d, mask_q;
    int               set_idx;
    int               clr_idx;
    logic             set_ok;

    always_comb begin
        set_idx = int'(set_y) * DOM_W + int'(set_x);
        clr_idx = int'(clr_y) * DOM_W + int'(clr_x);
        set_ok  = set_en && (int'(set_x) < DOM_W) && (int'(set_y) < DOM_H);
    end

    // One cell per domain element; a set in the same cycle as a clear wins.
    for (genvar gi = 0; gi < NCELL; gi++) begin : g_cell
        assign mask_d[gi] = (set_ok && (set_idx == gi)) ||
                            (mask_q[gi] && !(clr_en && (clr_idx == gi)));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            mask_q <= mask_d;
        end
    end

    // Lowest linear index wins: scan downward so the last hit is the lowest.
    always_comb begin
        pick_x = '0;
        pick_y = '0;
        for (int y = DOM_H - 1; y >= 0; y--) begin
            for (int x = DOM_W - 1; x >= 0; x--) begin
                if (mask_q[y * DOM_W + x]) begin
                    pick_x = XW'(x);
                    pick_y = YW'(y);
                end
            end
        end
    end

    assign any = |mask_q;

endmodule

// File: rtl/fdg_dual_issue.sv
module fdg_dual_issue
    import fdg_pkg::*;
#(
    parameter int DOM_W  = 16,
    parameter int DOM_H  = 16,
    parameter int DATA_W = 32,
    localparam int XW    = (DOM_W > 1) ? $clog2(DOM_W) : 1,
    localparam int YW    = (DOM_H > 1) ? $clog2(DOM_H) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dup_en,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [XW-1:0]     in_x,
    input  logic [YW-1:0]     in_y,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [XW-1:0]     out_x,
    output logic [YW-1:0]     out_y,
    output logic [DATA_W-1:0] out_data,
    output logic              out_replay,
    input  logic              rq_valid,
    input  logic [XW-1:0]     rq_x,
    input  logic [YW-1:0]     rq_y,
    output logic              busy
);

    typedef struct packed {
        phase_e        ph;
        src_e          src;
        logic [XW-1:0] hx;
        logic [YW-1:0] hy;
    } st_t;

    st_t st_d, st_q;

    logic          stg_valid;
    logic [XW-1:0] stg_x;
    logic [YW-1:0] stg_y;
    logic          mask_any;
    logic [XW-1:0] pick_x;
    logic [YW-1:0] pick_y;
    logic          clr_en;
    logic [XW-1:0] clr_x;
    logic [YW-1:0] clr_y;

    logic          offer;
    logic          last;
    logic          take;
    src_e          cur_src;
    logic [XW-1:0] cur_x;
    logic [YW-1:0] cur_y;

    fdg_req_stage #(.XW(XW), .YW(YW)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .rq_valid  (rq_valid),
        .rq_x      (rq_x),
        .rq_y      (rq_y),
        .stg_valid (stg_valid),
        .stg_x     (stg_x),
        .stg_y     (stg_y)
    );

    fdg_mask #(.DOM_W(DOM_W), .DOM_H(DOM_H), .XW(XW), .YW(YW)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (stg_valid),
        .set_x  (stg_x),
        .set_y  (stg_y),
        .clr_en (clr_en),
        .clr_x  (clr_x),
        .clr_y  (clr_y),
        .any    (mask_any),
        .pick_x (pick_x),
        .pick_y (pick_y)
    );

    always_comb begin
        st_d       = st_q;
        offer      = 1'b0;
        cur_src    = SRC_IN;
        cur_x      = pick_x;
        cur_y      = pick_y;
        in_ready   = 1'b0;
        clr_en     = 1'b0;
        clr_x      = st_q.hx;
        clr_y      = st_q.hy;

        // Choose or recall the source of the beat on the output.
        unique case (st_q.ph)
            PH_FREE: begin
                if (mask_any) begin
                    offer   = 1'b1;
                    cur_src = SRC_RPL;
                end else if (in_valid) begin
                    offer   = 1'b1;
                    cur_src = SRC_IN;
                end
            end
            PH_HELD, PH_SECOND: begin
                cur_src = st_q.src;
                cur_x   = st_q.hx;
                cur_y   = st_q.hy;
                offer   = (st_q.src == SRC_RPL) || in_valid;
            end
            default: ;
        endcase

        out_valid  = offer;
        out_x      = in_x;
        out_y      = in_y;
        out_data   = in_data;
        out_replay = 1'b0;
        if (cur_src == SRC_RPL) begin
            out_x      = cur_x;
            out_y      = cur_y;
            out_data   = '0;
            out_replay = 1'b1;
        end

        // A replay is always a pair; an input fragment is a pair only in reliable mode.
        last = (st_q.ph == PH_SECOND) || ((cur_src == SRC_IN) && !dup_en);
        take = offer && out_ready;

        if (take) begin
            if (last) begin
                st_d.ph = PH_FREE;
                if (cur_src == SRC_IN) begin
                    in_ready = 1'b1;
                end else begin
                    clr_en = 1'b1;
                end
            end else begin
                st_d.ph = PH_SECOND;
            end
        end else if (offer && (st_q.ph == PH_FREE)) begin
            st_d.ph = PH_HELD;
        end

        if (st_q.ph == PH_FREE) begin
            st_d.src = cur_src;
            st_d.hx  = cur_x;
            st_d.hy  = cur_y;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_FREE, src: SRC_IN, hx: '0, hy: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = stg_valid || mask_any;

endmodule

// File: rtl/fdg_dual_issue_chk.sv
module fdg_dual_issue_chk #(
    parameter int XW     = 4,
    parameter int YW     = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [XW-1:0]     out_x,
    input logic [YW-1:0]     out_y,
    input logic [DATA_W-1:0] out_data,
    input logic              out_replay,
    input logic              rq_valid,
    input logic              busy
);

    logic              rp_half_q;
    logic              in_half_q;
    logic [XW-1:0]     rx_q, ix_q;
    logic [YW-1:0]     ry_q, iy_q;
    logic [DATA_W-1:0] id_q;
    logic              hs;

    assign hs = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp_half_q <= 1'b0;
            in_half_q <= 1'b0;
            rx_q      <= '0;
            ry_q      <= '0;
            ix_q      <= '0;
            iy_q      <= '0;
            id_q      <= '0;
        end else if (hs) begin
            if (out_replay) begin
                rp_half_q <= !rp_half_q;
                rx_q      <= out_x;
                ry_q      <= out_y;
            end else begin
                in_half_q <= !in_ready;
                ix_q      <= out_x;
                iy_q      <= out_y;
                id_q      <= out_data;
            end
        end
    end

    AST_DUP_SECOND_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        in_half_q && out_valid |-> !out_replay && out_x == ix_q && out_y == iy_q && out_data == id_q); // R2

    AST_ACK_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> in_valid && out_valid && out_ready && !out_replay); // R3

    AST_REPLAY_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_replay |-> out_data == '0); // R7

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_x) && $stable(out_y) && $stable(out_data) && $stable(out_replay)); // R10

    AST_REQ_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rq_valid |=> busy); // R11

    AST_REPLAY_PAIR_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
        rp_half_q && out_valid |-> out_replay && out_x == rx_q && out_y == ry_q); // R12

endmodule

bind fdg_dual_issue fdg_dual_issue_chk #(.XW(XW), .YW(YW), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_x      (out_x),
    .out_y      (out_y),
    .out_data   (out_data),
    .out_replay (out_replay),
    .rq_valid   (rq_valid),
    .busy       (busy)
);

// File: tb/fdg_dual_issue_tb.sv
module fdg_dual_issue_tb;

    localparam int XW     = 4;
    localparam int YW     = 4;
    localparam int DATA_W = 32;
    localparam int PW     = XW + YW + DATA_W + 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              dup_en = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [XW-1:0]     in_x = '0;
    logic [YW-1:0]     in_y = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [XW-1:0]     out_x;
    logic [YW-1:0]     out_y;
    logic [DATA_W-1:0] out_data;
    logic              out_replay;
    logic              rq_valid = 1'b0;
    logic [XW-1:0]     rq_x = '0;
    logic [YW-1:0]     rq_y = '0;
    logic              busy;

    always #2 clk = ~clk;

    fdg_dual_issue u_dut (
        .clk(clk), .rst_n(rst_n), .dup_en(dup_en),
        .in_valid(in_valid), .in_ready(in_ready), .in_x(in_x), .in_y(in_y), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_x(out_x), .out_y(out_y),
        .out_data(out_data), .out_replay(out_replay),
        .rq_valid(rq_valid), .rq_x(rq_x), .rq_y(rq_y), .busy(busy)
    );

    typedef struct {
        logic [XW-1:0]     x;
        logic [YW-1:0]     y;
        logic [DATA_W-1:0] d;
        logic              rpl;
        logic              ack;
        string             tag;
    } item_t;

    item_t expq[$];
    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;

    int         rdy_mode = 0;
    bit         rdy_fix  = 1'b0;
    logic [15:0] pat     = 16'b1011_0010_1110_0101;

    task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Single driver of out_ready, updated just after each rising edge.
    always @(posedge clk) begin
        #1;
        if (rdy_mode != 0) begin
            out_ready = pat[0];
            pat = {pat[0], pat[15:1]};
        end else begin
            out_ready = rdy_fix;
        end
    end

    // Monitor: scoreboard pop on each handshake, plus stall stability.
    logic              pv_stall = 1'b0;
    logic [PW-1:0]     pv_beat  = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (pv_stall) begin
                chk(out_valid && ({out_x, out_y, out_data, out_replay, 1'b0} == pv_beat),
                    "R10", "stalled beat changed", 64'({out_valid, out_x, out_y, out_data, out_replay}),
                    64'({1'b1, pv_beat[PW-1:1]}));
            end
            pv_stall = out_valid && !out_ready;
            pv_beat  = {out_x, out_y, out_data, out_replay, 1'b0};
            if (out_valid && out_ready) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R2", "unexpected beat", 64'({out_x, out_y, out_data, out_replay, in_ready}), 64'(0));
                end else begin
                    item_t e;
                    e = expq.pop_front();
                    chk({out_x, out_y, out_data, out_replay, in_ready} == {e.x, e.y, e.d, e.rpl, e.ack},
                        e.tag, "beat {x,y,data,replay,in_ready}",
                        64'({out_x, out_y, out_data, out_replay, in_ready}),
                        64'({e.x, e.y, e.d, e.rpl, e.ack}));
                end
            end
        end
    end

    function automatic void exp_in(int x, int y, logic [DATA_W-1:0] d, bit dup, string tag);
        item_t e;
        e.x = XW'(x); e.y = YW'(y); e.d = d; e.rpl = 1'b0; e.tag = tag;
        if (dup) begin
            e.ack = 1'b0; expq.push_back(e);
        end
        e.ack = 1'b1; expq.push_back(e);
    endfunction

    function automatic void exp_rp(int x, int y, string tag);
        item_t e;
        e.x = XW'(x); e.y = YW'(y); e.d = '0; e.rpl = 1'b1; e.ack = 1'b0; e.tag = tag;
        expq.push_back(e);
        expq.push_back(e);
    endfunction

    task automatic send(int x, int y, logic [DATA_W-1:0] d);
        @(posedge clk); #1;
        in_x = XW'(x); in_y = YW'(y); in_data = d; in_valid = 1'b1;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic req(int x, int y);
        @(posedge clk); #1;
        rq_valid = 1'b1; rq_x = XW'(x); rq_y = YW'(y);
        @(posedge clk); #1;
        rq_valid = 1'b0;
    endtask

    task automatic drain();
        while (expq.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(busy == 1'b0, "R11", "busy after drain", 64'(busy), 64'(0));
        chk(out_valid == 1'b0, "R7", "output idle after drain", 64'(out_valid), 64'(0));
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R11 watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // Reset (R1)
        repeat (3) @(negedge clk);
        chk(!out_valid && !in_ready && !busy, "R1", "outputs in reset",
            64'({out_valid, in_ready, busy}), 64'(0));
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!out_valid && !in_ready && !busy, "R1", "outputs after reset",
            64'({out_valid, in_ready, busy}), 64'(0));

        // Reliable mode with irregular backpressure (R2, R3, R10)
        rdy_mode = 1;
        dup_en   = 1'b1;
        for (int i = 0; i < 6; i++) begin
            logic [DATA_W-1:0] d;
            d = 32'hA500_0000 + 32'(i) * 32'h0001_1111;
            exp_in(i + 3, 15 - i, d, 1'b1, "R2,R3");
            send(i + 3, 15 - i, d);
        end
        drain();

        // Pass-through mode (R4, R10)
        @(negedge clk);
        dup_en = 1'b0;
        for (int i = 0; i < 6; i++) begin
            logic [DATA_W-1:0] d;
            d = 32'h5A00_0000 ^ (32'(i) << 4);
            exp_in(2 * i, i, d, 1'b0, "R4");
            send(2 * i, i, d);
        end
        drain();

        // Requests land behind a held input, then replay in ascending order (R8, R9, R10, R11)
        @(negedge clk);
        dup_en   = 1'b1;
        rdy_mode = 0;
        rdy_fix  = 1'b0;
        fork
            send(4, 4, 32'hF1F1_0001);
        join_none
        repeat (2) @(negedge clk);
        req(9, 3);
        req(2, 1);
        req(15, 0);
        req(2, 1);
        req(0, 2);
        repeat (3) @(negedge clk);
        chk(busy == 1'b1, "R11", "busy with marks", 64'(busy), 64'(1));
        chk(out_valid && !out_replay && out_x == 4'd4, "R10", "held input keeps output",
            64'({out_valid, out_replay, out_x}), 64'({1'b1, 1'b0, 4'd4}));
        exp_in(4, 4, 32'hF1F1_0001, 1'b1, "R10");
        exp_rp(15, 0, "R8");
        exp_rp(2, 1, "R8,R9");
        exp_rp(0, 2, "R8");
        exp_rp(9, 3, "R8");
        rdy_fix = 1'b1;
        drain();

        // Replay precedence over waiting input (R6)
        @(negedge clk);
        rdy_fix = 1'b0;
        req(7, 7);
        repeat (2) @(negedge clk);
        fork
            send(6, 6, 32'hF2F2_0002);
        join_none
        req(1, 1);
        repeat (3) @(negedge clk);
        exp_rp(7, 7, "R6");
        exp_rp(1, 1, "R6");
        exp_in(6, 6, 32'hF2F2_0002, 1'b1, "R6");
        rdy_fix = 1'b1;
        drain();

        // Requests arriving during replay are kept (R9)
        @(negedge clk);
        rdy_fix = 1'b1;
        exp_rp(5, 0, "R9");
        exp_rp(7, 0, "R9");
        exp_rp(8, 12, "R9");
        req(5, 0);
        req(7, 0);
        req(8, 12);
        drain();

        // Capture timing and a lower-index request between copies (R5, R7, R12)
        @(negedge clk);
        rdy_fix = 1'b0;
        req(10, 0);
        @(negedge clk);
        chk(busy == 1'b1, "R5", "busy after capture", 64'(busy), 64'(1));
        chk(out_valid == 1'b0, "R5", "not yet in mask", 64'(out_valid), 64'(0));
        @(negedge clk);
        chk(out_valid && out_replay && out_x == 4'd10 && out_y == 4'd0 && out_data == '0,
            "R5", "replay offered after mask set",
            64'({out_valid, out_replay, out_x, out_y, out_data}),
            64'({1'b1, 1'b1, 4'd10, 4'd0, 32'd0}));
        exp_rp(10, 0, "R12");
        exp_rp(3, 0, "R12");
        rdy_fix = 1'b1;
        @(negedge clk);
        rdy_fix = 1'b0;
        req(3, 0);
        repeat (3) @(negedge clk);
        chk(out_valid && out_replay && out_x == 4'd10, "R12", "second copy kept",
            64'({out_valid, out_replay, out_x}), 64'({1'b1, 1'b1, 4'd10}));
        rdy_fix = 1'b1;
        drain();

        chk(expq.size() == 0, "R2", "beats left in scoreboard", 64'(expq.size()), 64'(0));
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule